// File: doc/BRIEF.md
# APB Control and Status Register Bank

This block is the subordinate end of an APB4 link: a small bank of 32-bit registers that software on the manager side reads and writes. A transfer is presented for one setup cycle (select high, enable low) and then held in the access phase (select and enable high) until the block raises its ready output. The number of access cycles that ready stays low is fixed by the `WAIT_STATES` parameter; with zero the transfer completes in the minimum two cycles.

Writes go through per-byte enables, one enable bit per 8-bit lane of the write data, so software can update a single byte without a read-modify-write. The bank holds `N_RW` read/write registers at word offsets 0 upward, followed by `N_RO` read-only status words. The first read-only word returns the `ID_VALUE` parameter; each later one returns the bitwise inverse of a read/write register, giving a live value that a faulty write path could disturb. Any access to an address beyond the bank, any address whose two low bits are not zero, and any write aimed at a read-only word completes with the error response and changes nothing.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset every read/write register reads as zero.
- R2: The ready output is low whenever select is low and during the setup cycle (select high, enable low); a transfer completes only on a cycle with select, enable and ready all high.
- R3: In the access phase ready stays low for exactly `WAIT_STATES` cycles (default 2) and is high on the following cycle.
- R4: On a completing write to a read/write register, byte lane n (write data bits 8n+7 down to 8n) is stored only when byte-enable bit n is 1; other lanes keep their value.
- R5: A completing read of a mapped, aligned word returns its current value; the byte-enable input has no effect on reads.
- R6: The read data output is all zeros on every cycle where no read is completing, including writes and idle cycles.
- R7: A word index (address bits above bit 1) of `N_RW+N_RO` or more is unmapped: the transfer completes with the error output high, read data zero, and no register changes.
- R8: An address whose bits 1:0 are not 00 completes with the error output high, read data zero, and no register changes.
- R9: Read-only words sit at word indices `N_RW` to `N_RW+N_RO-1` (byte offsets 0x10 and 0x14 by default); index `N_RW` reads `ID_VALUE` and index `N_RW+k` (k at least 1) reads the inverse of read/write register k-1. A write to them completes with the error output high and alters no register.
- R10: The error output is high only on a completing cycle of an erroneous transfer; it is low on successful completions and when no transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Subordinate selected |
| enable | input | 1 | Access phase marker |
| writeEn | input | 1 | 1 for write, 0 for read |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| byteEn | input | DATA_W/8 | Per-lane write enables |
| rdata | output | DATA_W | Read data, zero unless a read completes |
| ready | output | 1 | Transfer completes this cycle |
| errResp | output | 1 | Completing transfer is in error |

## Verification
The bench counts the access cycles before ready on every transfer; a counter that did not clear between transfers or counted setup would shorten or stretch the wait. Writes with sparse byte enables, including all-zero enables, are compared lane by lane against a model, so a design that wrote whole words would show wrong bytes on the next read. Unaligned, unmapped and read-only targets are each written and then read back through the mapped words, catching a design that flags the error yet still commits the data, and the inverted status word exposes a write that leaks into register 0. Reads are issued with random byte enables to show they are ignored, and read data is checked zero between and during writes.

// File: rtl/rb_pkg.sv
package rb_pkg;
  // Per-transfer strobes from the control path to the datapath
  typedef struct packed {
    logic commitWr;  // store byte lanes this cycle
    logic driveRd;   // put the selected word on the read bus
    logic flagErr;   // completing transfer is rejected
  } rbStrobe_t;
endpackage

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int N_RW        = 4,
  parameter int N_RO        = 2,
  parameter int WAIT_STATES = 2,
  localparam int IDX_W      = ADDR_W - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel,
  input  logic             enable,
  input  logic             writeEn,
  input  logic [ADDR_W-1:0] addr,
  output rbStrobe_t        strobe,
  output logic [IDX_W-1:0] wordIdx,
  output logic             ready
);
  localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

  logic [CNT_W-1:0] waitCnt;
  logic accessPhase, inRw, inRo, badAccess;

  assign accessPhase = sel && enable;
  assign ready       = accessPhase && (waitCnt == CNT_W'(WAIT_STATES));
  assign wordIdx     = addr[ADDR_W-1:2];

  // Wait counter clears outside access and after each completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       waitCnt <= '0;
    else if (accessPhase && !ready)  waitCnt <= waitCnt + 1'b1;
    else                             waitCnt <= '0;
  end

  // Address decode
  assign inRw      = wordIdx < IDX_W'(N_RW);
  assign inRo      = (wordIdx >= IDX_W'(N_RW)) && (wordIdx < IDX_W'(N_RW + N_RO));
  assign badAccess = (addr[1:0] != 2'b00) || !(inRw || inRo) || (writeEn && inRo);

  always_comb begin
    strobe.commitWr = ready && writeEn && !badAccess;
    strobe.driveRd  = ready && !writeEn && !badAccess;
    strobe.flagErr  = ready && badAccess;
  end
endmodule

// File: rtl/rb_store.sv
module rb_store
  import rb_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          N_RW     = 4,
  parameter int          N_RO     = 2,
  parameter int          IDX_W    = 10,
  parameter logic [31:0] ID_VALUE = 32'hC0DE_0A5B,
  localparam int         LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbStrobe_t         strobe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rwReg [N_RW];
  logic [DATA_W-1:0] roVal [N_RO];
  logic [DATA_W-1:0] readVal;

  // Byte-lane storage
  for (genvar r = 0; r < N_RW; r++) begin : g_reg
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          rwReg[r][8*b +: 8] <= '0;
        else if (strobe.commitWr && wordIdx == IDX_W'(r) && byteEn[b])
          rwReg[r][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  // Read-only words: identifier, then inverted mirrors
  for (genvar g = 0; g < N_RO; g++) begin : g_ro
    if (g == 0) begin : g_id
      assign roVal[g] = DATA_W'(ID_VALUE);
    end else begin : g_inv
      assign roVal[g] = ~rwReg[(g - 1) % N_RW];
    end
  end

  always_comb begin
    readVal = '0;
    for (int r = 0; r < N_RW; r++)
      if (wordIdx == IDX_W'(r)) readVal = rwReg[r];
    for (int g = 0; g < N_RO; g++)
      if (wordIdx == IDX_W'(N_RW + g)) readVal = roVal[g];
  end

  assign rdata = strobe.driveRd ? readVal : '0;
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import rb_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          N_RW        = 4,
  parameter int          N_RO        = 2,
  parameter int          WAIT_STATES = 2,
  parameter logic [31:0] ID_VALUE    = 32'hC0DE_0A5B,
  localparam int         LANES       = DATA_W / 8,
  localparam int         IDX_W       = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              enable,
  input  logic              writeEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              errResp
);
  rbStrobe_t        strobe;
  logic [IDX_W-1:0] wordIdx;

  rb_ctrl #(
    .ADDR_W(ADDR_W), .N_RW(N_RW), .N_RO(N_RO), .WAIT_STATES(WAIT_STATES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sel(sel), .enable(enable), .writeEn(writeEn),
    .addr(addr), .strobe(strobe), .wordIdx(wordIdx), .ready(ready)
  );

  rb_store #(
    .DATA_W(DATA_W), .N_RW(N_RW), .N_RO(N_RO), .IDX_W(IDX_W), .ID_VALUE(ID_VALUE)
  ) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .wdata(wdata), .byteEn(byteEn), .rdata(rdata)
  );

  assign errResp = strobe.flagErr;
endmodule

// File: rtl/rb_chk.sv
module rb_chk #(
  parameter int DATA_W      = 32,
  parameter int WAIT_STATES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              sel,
  input logic              enable,
  input logic              writeEn,
  input logic              ready,
  input logic              errResp,
  input logic [DATA_W-1:0] rdata
);
  int waitSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        waitSeen <= 0;
    else if (sel && enable && !ready) waitSeen <= waitSeen + 1;
    else                              waitSeen <= 0;
  end

  // R2
  setup_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !enable) |-> !ready);
  // R2
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sel |-> !ready);
  // R3
  wait_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (waitSeen == WAIT_STATES));
  // R10
  err_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    errResp |-> ready);
  // R6
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ready || writeEn) |-> (rdata == '0));
  // R7
  err_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    errResp |-> (rdata == '0));
endmodule

bind ctrl_reg_bank rb_chk #(.DATA_W(DATA_W), .WAIT_STATES(WAIT_STATES)) uChk (
  .clk(clk), .rstN(rstN), .sel(sel), .enable(enable), .writeEn(writeEn),
  .ready(ready), .errResp(errResp), .rdata(rdata)
);

// File: tb/sim_ctrl_reg_bank.sv
`timescale 1ns/1ps
module sim_ctrl_reg_bank;
  localparam int          WAITS = 2;
  localparam logic [31:0] IDV   = 32'hC0DE_0A5B;

  logic        clk = 0;
  logic        rstN = 0;
  logic        sel = 0, enable = 0, writeEn = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  byteEn = '0;
  logic [31:0] rdata;
  logic        ready, errResp;

  int total = 0, bad = 0;
  logic [31:0] model [4];

  always #2.5 clk = ~clk;

  ctrl_reg_bank #(.WAIT_STATES(WAITS), .ID_VALUE(IDV)) u0 (
    .clk(clk), .rstN(rstN), .sel(sel), .enable(enable), .writeEn(writeEn),
    .addr(addr), .wdata(wdata), .byteEn(byteEn), .rdata(rdata),
    .ready(ready), .errResp(errResp)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit expErr(input logic [11:0] a, input bit wr);
    int idx = int'(a[11:2]);
    return (a[1:0] != 2'b00) || (idx >= 6) || (wr && idx >= 4);
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    int idx = int'(a[11:2]);
    if (expErr(a, 1'b0)) return '0;
    if (idx < 4)  return model[idx];
    if (idx == 4) return IDV;
    return ~model[0];
  endfunction

  // One transfer; returns read data and error seen on the completing cycle
  task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd, output logic er);
    int waits = 0;
    @(negedge clk);
    sel = 1; enable = 0; writeEn = wr; addr = a; wdata = d; byteEn = be;
    #1;
    check(ready == 0, "R2 setup ready", 32'(ready), 0);
    @(negedge clk);
    enable = 1;
    #1;
    while (!ready) begin
      check(rdata == 0 && errResp == 0, "R6 R10 outputs quiet while waiting", rdata, 0);
      @(negedge clk); #1;
      waits++;
    end
    check(waits == WAITS, "R3 wait count", 32'(waits), WAITS);
    rd = rdata; er = errResp;
    if (wr) check(rdata == 0, "R6 rdata zero on write", rdata, 0);
    @(negedge clk);
    sel = 0; enable = 0; byteEn = '0;
    #1;
    check(ready == 0 && errResp == 0 && rdata == 0, "R2 R6 R10 idle quiet",
          {rdata[29:0], ready, errResp}, 0);
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be, input string req);
    logic [31:0] rd; logic er; bit e;
    e = expErr(a, 1'b1);
    xfer(1'b1, a, d, be, rd, er);
    check(er == e, req, 32'(er), 32'(e));
    if (!e)
      for (int b = 0; b < 4; b++)
        if (be[b]) model[a[3:2]][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic doRead(input logic [11:0] a, input logic [3:0] be, input string req);
    logic [31:0] rd; logic er; bit e; logic [31:0] x;
    e = expErr(a, 1'b0);
    x = expRead(a);
    xfer(1'b0, a, 32'h0, be, rd, er);
    check(er == e, {req, " err"}, 32'(er), 32'(e));
    check(rd == x, {req, " data"}, rd, x);
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < 6; i++) doRead(12'(i * 4), 4'h0, req);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", 150000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] a;
    int unsigned seed;
    for (int i = 0; i < 4; i++) model[i] = '0;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    #1;
    check(ready == 0 && errResp == 0 && rdata == 0, "R2 reset outputs", rdata, 0);
    rstN = 1;

    // R1 reset values, R9 id and inverted mirror
    readAll("R1 R9 reset readback");

    // R4 full and sparse byte writes
    doWrite(12'h000, 32'h1122_3344, 4'hF, "R4 full write");
    doWrite(12'h000, 32'hAABB_CCDD, 4'b0101, "R4 sparse write");
    doWrite(12'h004, 32'hFFFF_FFFF, 4'h0, "R4 no-lane write");
    doWrite(12'h00C, 32'h5566_7788, 4'b1000, "R4 top lane");
    readAll("R4 R9 after byte writes");

    // R5 reads ignore byte enables
    doRead(12'h000, 4'hF, "R5 read with enables");

    // R8 unaligned write then read
    doWrite(12'h002, 32'hDEAD_BEEF, 4'hF, "R8 unaligned write");
    doRead(12'h005, 4'h0, "R8 unaligned read");
    // R7 unmapped write then read
    doWrite(12'h018, 32'hDEAD_BEEF, 4'hF, "R7 unmapped write");
    doWrite(12'hFFC, 32'hDEAD_BEEF, 4'hF, "R7 top unmapped write");
    doRead(12'h018, 4'h0, "R7 unmapped read");
    // R9 writes to read-only words
    doWrite(12'h010, 32'h0BAD_F00D, 4'hF, "R9 write id");
    doWrite(12'h014, 32'h0BAD_F00D, 4'hF, "R9 write mirror");
    readAll("R7 R8 R9 state unchanged");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned pick = $urandom % 10;
      if (pick < 7) a = 12'(($urandom % 6) * 4);
      else if (pick < 8) a = 12'(($urandom % 6) * 4 + 1 + ($urandom % 3));
      else a = 12'(24 + ($urandom % 1000) * 4);
      if ($urandom % 2) doWrite(a, $urandom, 4'($urandom), "R4 R7 R8 R9 random write");
      else doRead(a, 4'($urandom), "R5 R7 R8 R9 random read");
    end
    readAll("R4 R5 final readback");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule